// File: doc/BRIEF.md
# Boot Processor Failover Supervisor

This block watches the start-up of a multiprocessor system and makes sure a working boot processor is eventually found. Each time the system comes out of reset, a start-up timer runs. Firmware on the selected boot processor proves it is alive by raising the halt input, which stops the timer and ends supervision until the next hard reset. If the timer runs out first, the block retires the selected processor in a failure mask that survives system resets, pulses an event strobe carrying that processor's index to an external event log, picks the next healthy processor and drives a system reset pulse.

Selection walks upward through the processor indices from the one that just failed, wrapping at the top and skipping failed processors. Once every processor is marked failed, the block switches to a last-resort mode. In that mode it ignores the failure history and tries the processors one at a time, in index order, each as the only enabled processor. Only the power-on reset clears the failure mask and the last-resort mode.

Top module: `boot_failover_sup`

## Requirements
- R1: While por_n is low, sys_rst_o is 1, boot_cpu_o is 0, failed_o is all zeros and last_resort_o is 0. After por_n rises, sys_rst_o stays 1 for RST_CYC+1 clock cycles (two-stage reset synchronizer, then the reset pulse).
- R2: Once sys_rst_o falls, if halt_i stays low, evt_stb_o rises exactly TMO_CYC clock cycles later (in the (TMO_CYC+1)-th cycle counted from the first cycle with sys_rst_o low).
- R3: A halt_i pulse while the timer runs stops it: no event strobe and no system reset follow, and the status outputs do not change.
- R4: A halt_i that is high in the final timer cycle wins over expiry: no failure is recorded and no event strobe is produced.
- R5: On expiry evt_stb_o is high for exactly one cycle, evt_id_o equals the processor that timed out, and that processor's bit in failed_o (bit i for processor i) is set.
- R6: The cycle after the event strobe, sys_rst_o goes high for exactly RST_CYC cycles, after which the timer runs again.
- R7: Outside last-resort mode the next boot processor is the first processor not marked failed, searching in ascending index order from the failed one plus one, wrapping from N_CPU-1 to 0.
- R8: Outside last-resort mode cpu_en_o is the bitwise inverse of failed_o.
- R9: When the failure mask becomes all ones, last_resort_o goes high and stays high; from then on cpu_en_o has only the boot_cpu_o bit set, and each timeout advances boot_cpu_o by one, wrapping, while failed_o stays all ones.
- R10: A one-cycle hrst_i pulse while the timer runs or after a halt produces a system reset pulse of RST_CYC cycles and re-arms the timer without changing boot_cpu_o, failed_o or last_resort_o.
- R11: The failure mask and last-resort mode survive sys_rst_o pulses and are cleared only by por_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous active low |
| halt_i | input | 1 | Boot processor alive indication, stops the timer |
| hrst_i | input | 1 | Hard reset request, re-arms the timer |
| cpu_en_o | output | N_CPU | Processor enable mask, bit i for processor i |
| sys_rst_o | output | 1 | System reset, active high |
| evt_stb_o | output | 1 | One-cycle error event strobe |
| evt_id_o | output | $clog2(N_CPU) | Index of the processor that timed out |
| boot_cpu_o | output | $clog2(N_CPU) | Currently selected boot processor |
| failed_o | output | N_CPU | Failure mask, bit i for processor i |
| last_resort_o | output | 1 | Last-resort mode flag |

## Verification
The assertions check on every cycle that the event strobe lasts one cycle and is followed by system reset, that the failure mask only ever gains bits, that the timer counter never passes its limit, that the selected processor is healthy outside last-resort mode, and that last-resort mode implies an all-ones mask with a single enabled processor. Only the bench scenarios can show the exact timeout and reset pulse lengths, the halt-at-expiry race, the selection order across a full sequence of failures into last-resort rotation, and that only power-on clears the history.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_TIMING = 2'd1,
    ST_LOG    = 2'd2,
    ST_DONE   = 2'd3
  } bfs_state_e;
endpackage

// File: rtl/bfs_rst_sync.sv
module bfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[s] <= 1'b0;
          else         sync_q[s] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[s] <= 1'b0;
          else         sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bfs_fsm.sv
module bfs_fsm
  import bfs_pkg::*;
#(
  parameter int TMO_CYC = 20,
  parameter int RST_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic hrst_i,
  output logic log_o,
  output logic sys_rst_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TMO_CYC - 1);
  localparam logic [RW-1:0] R_LAST = RW'(RST_CYC - 1);

  bfs_state_e st_q, st_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [RW-1:0] pcnt_q, pcnt_d;
  logic          tcnt_en, pcnt_en;

  always_comb begin
    st_d    = st_q;
    tcnt_d  = tcnt_q;
    pcnt_d  = pcnt_q;
    tcnt_en = 1'b0;
    pcnt_en = 1'b0;
    unique case (st_q)
      ST_RESET: begin
        pcnt_en = 1'b1;
        if (pcnt_q == R_LAST) begin
          st_d    = ST_TIMING;
          tcnt_en = 1'b1;
          tcnt_d  = '0;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end
      ST_TIMING: begin
        if (hrst_i) begin
          st_d    = ST_RESET;
          pcnt_en = 1'b1;
          pcnt_d  = '0;
        end else if (halt_i) begin
          st_d = ST_DONE;
        end else if (tcnt_q == T_LAST) begin
          st_d = ST_LOG;
        end else begin
          tcnt_en = 1'b1;
          tcnt_d  = tcnt_q + 1'b1;
        end
      end
      ST_LOG: begin
        st_d    = ST_RESET;
        pcnt_en = 1'b1;
        pcnt_d  = '0;
      end
      ST_DONE: begin
        if (hrst_i) begin
          st_d    = ST_RESET;
          pcnt_en = 1'b1;
          pcnt_d  = '0;
        end
      end
      default: st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RESET;
      tcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (tcnt_en) tcnt_q <= tcnt_d;
      if (pcnt_en) pcnt_q <= pcnt_d;
    end
  end

  assign log_o     = (st_q == ST_LOG);
  assign sys_rst_o = (st_q == ST_RESET);

  AST_TMO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TIMING) |-> (tcnt_q <= T_LAST)) else $error("timer over limit"); // R2
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESET) |-> (pcnt_q <= R_LAST)) else $error("pulse over limit"); // R6
  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    log_o |=> !log_o) else $error("strobe too long"); // R5
  AST_EVT_THEN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    log_o |=> sys_rst_o) else $error("no reset after event"); // R6
endmodule

// File: rtl/bfs_tracker.sv
module bfs_tracker #(
  parameter int N_CPU = 4,
  localparam int IDW = $clog2(N_CPU)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_i,
  output logic [IDW-1:0] cur_o,
  output logic [N_CPU-1:0] failed_o,
  output logic           lr_o,
  output logic [N_CPU-1:0] cpu_en_o
);
  logic [IDW-1:0]   cur_q, cur_d;
  logic [N_CPU-1:0] failed_q, failed_d;
  logic             lr_q, lr_d;
  logic [N_CPU-1:0] cur_hot;
  logic [IDW-1:0]   step_one;
  logic [IDW-1:0]   healthy_nxt;
  logic             found;

  assign cur_hot = N_CPU'(1) << cur_q;

  always_comb begin
    int s;
    s        = (int'(cur_q) + 1) % N_CPU;
    step_one = s[IDW-1:0];
  end

  always_comb begin
    found       = 1'b0;
    healthy_nxt = cur_q;
    for (int k = 1; k <= N_CPU; k++) begin
      int s;
      s = (int'(cur_q) + k) % N_CPU;
      if (!found && !failed_d[s]) begin
        found       = 1'b1;
        healthy_nxt = s[IDW-1:0];
      end
    end
  end

  always_comb begin
    failed_d = failed_q | cur_hot;
    lr_d     = lr_q | (&failed_d);
    if (lr_d) cur_d = step_one;
    else      cur_d = healthy_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      failed_q <= '0;
      lr_q     <= 1'b0;
    end else if (upd_i) begin
      cur_q    <= cur_d;
      failed_q <= failed_d;
      lr_q     <= lr_d;
    end
  end

  assign cur_o    = cur_q;
  assign failed_o = failed_q;
  assign lr_o     = lr_q;
  assign cpu_en_o = lr_q ? cur_hot : ~failed_q;

  AST_FAIL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((failed_q & $past(failed_q)) == $past(failed_q))) else $error("mask lost bits"); // R11
  AST_LR_ALL_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
    lr_q |-> (&failed_q)) else $error("last resort without full mask"); // R9
  AST_LR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lr_q |=> lr_q) else $error("last resort dropped"); // R9
  AST_CUR_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
    !lr_q |-> !failed_q[cur_q]) else $error("failed cpu selected"); // R7
endmodule

// File: rtl/boot_failover_sup.sv
module boot_failover_sup #(
  parameter int N_CPU   = 4,
  parameter int CLK_HZ  = 100_000_000,
  parameter int TMO_SEC = 5,
  parameter int TMO_CYC = CLK_HZ * TMO_SEC,
  parameter int RST_CYC = 16,
  localparam int IDW = $clog2(N_CPU)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             halt_i,
  input  logic             hrst_i,
  output logic [N_CPU-1:0] cpu_en_o,
  output logic             sys_rst_o,
  output logic             evt_stb_o,
  output logic [IDW-1:0]   evt_id_o,
  output logic [IDW-1:0]   boot_cpu_o,
  output logic [N_CPU-1:0] failed_o,
  output logic             last_resort_o
);
  logic rst_n;
  logic log_w;

  bfs_rst_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (rst_n)
  );

  bfs_fsm #(.TMO_CYC(TMO_CYC), .RST_CYC(RST_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_i    (halt_i),
    .hrst_i    (hrst_i),
    .log_o     (log_w),
    .sys_rst_o (sys_rst_o)
  );

  bfs_tracker #(.N_CPU(N_CPU)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (log_w),
    .cur_o    (boot_cpu_o),
    .failed_o (failed_o),
    .lr_o     (last_resort_o),
    .cpu_en_o (cpu_en_o)
  );

  assign evt_stb_o = log_w;
  assign evt_id_o  = boot_cpu_o;

  AST_LR_ONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    last_resort_o |-> $onehot(cpu_en_o)) else $error("several cpus enabled"); // R9
  AST_EN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !last_resort_o |-> (cpu_en_o == ~failed_o)) else $error("enable mismatch"); // R8
endmodule

// File: tb/sim_boot_failover_sup.sv
module sim_boot_failover_sup;
  localparam int N   = 4;
  localparam int TMO = 20;
  localparam int RST = 3;
  localparam int IDW = $clog2(N);

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic halt_i = 1'b0;
  logic hrst_i = 1'b0;
  logic [N-1:0]   cpu_en_o;
  logic           sys_rst_o;
  logic           evt_stb_o;
  logic [IDW-1:0] evt_id_o;
  logic [IDW-1:0] boot_cpu_o;
  logic [N-1:0]   failed_o;
  logic           last_resort_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  boot_failover_sup #(.N_CPU(N), .TMO_CYC(TMO), .RST_CYC(RST)) u0 (
    .clk(clk), .por_n(por_n), .halt_i(halt_i), .hrst_i(hrst_i),
    .cpu_en_o(cpu_en_o), .sys_rst_o(sys_rst_o), .evt_stb_o(evt_stb_o),
    .evt_id_o(evt_id_o), .boot_cpu_o(boot_cpu_o), .failed_o(failed_o),
    .last_resort_o(last_resort_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count negedges with sys_rst_o high; ends on first timer cycle
  task automatic count_rst(output int c);
    c = 0;
    forever begin
      @(negedge clk);
      if (!sys_rst_o) break;
      c++;
    end
  endtask

  task automatic chk_status(input string req, input int cur, input int fm, input int lr);
    chk({req, " boot_cpu"}, int'(boot_cpu_o), cur);
    chk({req, " failed"}, int'(failed_o), fm);
    chk({req, " last_resort"}, int'(last_resort_o), lr);
    if (lr != 0) chk({req, " cpu_en onehot"}, int'(cpu_en_o), 1 << cur);
    else         chk({req, " cpu_en"}, int'(cpu_en_o), (~fm) & ((1 << N) - 1));
  endtask

  task automatic t_por();
    int c;
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rst during por", int'(sys_rst_o), 1);
    chk_status("R1", 0, 0, 0);
    por_n = 1'b1;
    count_rst(c);
    chk("R1 release length", c, RST + 1);
    chk_status("R1 after", 0, 0, 0);
  endtask

  // starts on first timer cycle; expects timeout of exp_id
  task automatic t_timeout(input int exp_id, input int nxt, input int fm, input int lr);
    int n, c;
    n = 1;
    while (!evt_stb_o && n < TMO + 10) begin
      @(negedge clk);
      n++;
    end
    chk("R2 timeout cycles", n, TMO + 1);
    chk("R5 evt id", int'(evt_id_o), exp_id);
    @(negedge clk);
    chk("R5 strobe one cycle", int'(evt_stb_o), 0);
    chk("R6 reset follows", int'(sys_rst_o), 1);
    c = 1;
    count_rst(c);
    c = c + 1;
    chk("R6 pulse length", c, RST);
    chk_status("R7 R11 status", nxt, fm, lr);
  endtask

  task automatic watch_quiet(input string req, input int cycles);
    int ev, rs;
    ev = 0; rs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (evt_stb_o) ev++;
      if (sys_rst_o) rs++;
    end
    chk({req, " no event"}, ev, 0);
    chk({req, " no reset"}, rs, 0);
  endtask

  // halt after k timer cycles (k=TMO is the final cycle)
  task automatic t_halt(input string req, input int k, input int cur, input int fm, input int lr);
    for (int i = 1; i < k; i++) @(negedge clk);
    halt_i = 1'b1;
    @(negedge clk);
    halt_i = 1'b0;
    watch_quiet(req, 2 * TMO);
    chk_status(req, cur, fm, lr);
  endtask

  task automatic t_hrst(input int cur, input int fm, input int lr);
    int c;
    hrst_i = 1'b1;
    @(negedge clk);
    hrst_i = 1'b0;
    chk("R10 reset on request", int'(sys_rst_o), 1);
    c = 1;
    count_rst(c);
    c = c + 1;
    chk("R10 pulse length", c, RST);
    chk_status("R10 state kept", cur, fm, lr);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 50000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    t_por();
    t_halt("R3 early halt", 5, 0, 0, 0);
    t_hrst(0, 0, 0);
    t_timeout(0, 1, 4'b0001, 0);
    t_timeout(1, 2, 4'b0011, 0);
    t_halt("R4 halt at expiry", TMO, 2, 4'b0011, 0);
    t_hrst(2, 4'b0011, 0);
    t_timeout(2, 3, 4'b0111, 0);
    t_timeout(3, 0, 4'b1111, 1);          // R9 entry, wrap to 0
    t_timeout(0, 1, 4'b1111, 1);          // R9 rotation
    t_timeout(1, 2, 4'b1111, 1);
    t_timeout(2, 3, 4'b1111, 1);
    t_timeout(3, 0, 4'b1111, 1);
    t_halt("R9 halt in last resort", 7, 0, 4'b1111, 1);
    t_hrst(0, 4'b1111, 1);                // R11 survives reset
    t_por();                               // R11 cleared by por
    t_timeout(0, 1, 4'b0001, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule